// File: doc/BRIEF.md
# Byte and Halfword Load/Store Unit

This unit turns one decoded memory instruction into a single access on a byte-addressed data memory whose words are 16 bits wide. The core hands it the opcode, the values of the two registers named by the instruction, the destination index and a 5-bit signed offset. The unit forms the effective address, picks the byte lanes and drives a request that is held until the memory answers with a one-cycle ready. For loads it then returns the extended 16-bit result together with the destination index.

The two store forms take their address base from the register in the destination field and their data from the register in the first-source field. Loads take their base from the first-source register. Memory is little-endian. A halfword access to an odd address is refused with an alignment fault. The three reserved opcodes raise an illegal-instruction flag. Neither case touches memory, and neither produces a write-back. Any other opcode is not a memory operation and is ignored.

Top module: `lsu16`

## Requirements
- R1: The access address is the base register value plus the sign-extended 5-bit offset, modulo 2^16. It is presented on memAddr in the cycle after acceptance and held while memReq is high.
- R2: Opcode 0x08 (halfword store) uses dstRegVal as base and writes srcRegVal with memBe=11 and memWe=1. The low byte lands at the even address and the high byte at the odd address.
- R3: Opcode 0x09 (halfword load) uses srcRegVal as base. One cycle after the cycle in which memReady is high, loadValid pulses for one cycle with loadData equal to memRdata and wbIdx equal to the accepted dstIdx.
- R4: Opcode 0x0A (byte store) uses dstRegVal as base and writes only the low byte of srcRegVal. At an even address it uses memWdata[7:0] with memBe=01; at an odd address it uses memWdata[15:8] with memBe=10.
- R5: Opcode 0x0B (signed byte load) returns the addressed lane sign-extended to 16 bits. Bits 7:0 are used for an even address and bits 15:8 for an odd one.
- R6: Opcode 0x0C (unsigned byte load) returns the addressed lane zero-extended to 16 bits.
- R7: A halfword opcode (0x08 or 0x09) at an odd address pulses faultMisalign for one cycle after acceptance. It issues no request and no write, and loadValid stays low.
- R8: Opcodes 0x0D, 0x0E and 0x0F pulse faultIllegal for one cycle after acceptance and issue no request.
- R9: While a request is outstanding, busy is high, memAddr, memBe, memWdata and memWe hold steady until memReady, and opValid is ignored.
- R10: Opcodes outside 0x08 to 0x0F cause no request, no fault and no write-back.
- R11: After reset, memReq, memWe, loadValid, faultMisalign, faultIllegal and busy are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Instruction presented this cycle |
| opCode | input | 5 | Instruction opcode |
| dstRegVal | input | 16 | Value of the register in the destination field |
| srcRegVal | input | 16 | Value of the register in the first-source field |
| offset | input | 5 | Signed address offset |
| dstIdx | input | 3 | Destination register index |
| memAddr | output | 16 | Byte address of the access |
| memBe | output | 2 | Byte enables, bit 0 for bits 7:0 |
| memWdata | output | 16 | Write data |
| memWe | output | 1 | Write strobe |
| memReq | output | 1 | Access request |
| memRdata | input | 16 | Read data of the addressed word |
| memReady | input | 1 | Memory completes the request this cycle |
| loadValid | output | 1 | Load result valid (write-back enable) |
| loadData | output | 16 | Extended load result |
| wbIdx | output | 3 | Destination index of the load result |
| faultMisalign | output | 1 | Odd halfword address fault |
| faultIllegal | output | 1 | Reserved opcode fault |
| busy | output | 1 | Request outstanding |

## Verification
The properties assume that memReady rises only while memReq is high. They also assume that memRdata carries the addressed word in the cycle that memReady is high. The bench's memory model raises ready only after it has seen a request at the falling edge, and it serves data combinationally from its byte array, so both assumptions hold. Instructions are offered in idle cycles, except in one scenario that deliberately offers a store during a pending load to show it is dropped.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  parameter int DATA_W = 16;
  parameter int OFF_W = 5;
  parameter int IDX_W = 3;
  localparam int LANES = DATA_W / 8;
  localparam int LANE_BITS = $clog2(LANES);

  localparam logic [4:0] OP_ST_HALF  = 5'h08;
  localparam logic [4:0] OP_LD_HALF  = 5'h09;
  localparam logic [4:0] OP_ST_BYTE  = 5'h0A;
  localparam logic [4:0] OP_LD_BYTE  = 5'h0B;
  localparam logic [4:0] OP_LD_UBYTE = 5'h0C;
  localparam logic [4:0] OP_RSV_LO   = 5'h0D;
  localparam logic [4:0] OP_RSV_HI   = 5'h0F;

  typedef enum logic {S_IDLE, S_ACCESS} lsu_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch address, lanes and data of a new access
    logic isStore;   // base comes from the destination-field register
    logic isByte;    // single-lane access
    logic signExt;   // sign-extend the loaded byte
    logic takeData;  // memory answered a load this cycle
  } lsu_strobe_t;
endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        opValid,
  input  logic [4:0]  opCode,
  input  logic        misaligned,
  input  logic        memReady,
  output lsu_strobe_t strobe,
  output logic        memReq,
  output logic        memWe,
  output logic        loadValid,
  output logic        faultMisalign,
  output logic        faultIllegal,
  output logic        busy
);
  lsu_state_t state, stateNext;
  logic storeQ;
  logic accept, isMem, isRsv, halfFault;

  always_comb begin
    accept = (state == S_IDLE) && opValid;
    isMem = (opCode >= OP_ST_HALF) && (opCode <= OP_LD_UBYTE);
    isRsv = (opCode >= OP_RSV_LO) && (opCode <= OP_RSV_HI);
    strobe.isStore = (opCode == OP_ST_HALF) || (opCode == OP_ST_BYTE);
    strobe.isByte = (opCode == OP_ST_BYTE) || (opCode == OP_LD_BYTE) ||
                    (opCode == OP_LD_UBYTE);
    strobe.signExt = (opCode == OP_LD_BYTE);
    halfFault = accept && isMem && !strobe.isByte && misaligned;
    strobe.capture = accept && isMem && !halfFault;
    strobe.takeData = (state == S_ACCESS) && memReady && !storeQ;
    stateNext = state;
    case (state)
      S_IDLE:   if (strobe.capture) stateNext = S_ACCESS;
      S_ACCESS: if (memReady) stateNext = S_IDLE;
      default:  stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      storeQ <= 1'b0;
      loadValid <= 1'b0;
      faultMisalign <= 1'b0;
      faultIllegal <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.capture) storeQ <= strobe.isStore;
      loadValid <= strobe.takeData;
      faultMisalign <= halfFault;
      faultIllegal <= accept && isRsv;
    end
  end

  assign memReq = (state == S_ACCESS);
  assign memWe = memReq && storeQ;
  assign busy = memReq;
endmodule

// File: rtl/lsu_dp.sv
module lsu_dp
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  lsu_strobe_t       strobe,
  input  logic [DATA_W-1:0] dstRegVal,
  input  logic [DATA_W-1:0] srcRegVal,
  input  logic [OFF_W-1:0]  offset,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [DATA_W-1:0] memRdata,
  output logic              misaligned,
  output logic [DATA_W-1:0] memAddr,
  output logic [LANES-1:0]  memBe,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] loadData,
  output logic [IDX_W-1:0]  wbIdx
);
  logic [DATA_W-1:0] baseVal, effAddr, addrQ, wdataQ;
  logic [LANES-1:0]  beNext, beQ;
  logic              byteQ, signQ;
  logic [7:0]        laneBytes [LANES];
  logic [7:0]        selByte;

  always_comb begin
    baseVal = strobe.isStore ? dstRegVal : srcRegVal;
    effAddr = baseVal + {{(DATA_W-OFF_W){offset[OFF_W-1]}}, offset};
    misaligned = (effAddr[LANE_BITS-1:0] != '0);
    beNext = strobe.isByte ? (LANES'(1) << effAddr[LANE_BITS-1:0]) : '1;
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign laneBytes[b] = memRdata[8*b +: 8];
  end
  assign selByte = laneBytes[addrQ[LANE_BITS-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ <= '0;
      wdataQ <= '0;
      beQ <= '0;
      byteQ <= 1'b0;
      signQ <= 1'b0;
      wbIdx <= '0;
      loadData <= '0;
    end else begin
      if (strobe.capture) begin
        addrQ <= effAddr;
        beQ <= beNext;
        wdataQ <= strobe.isByte ? {LANES{srcRegVal[7:0]}} : srcRegVal;
        byteQ <= strobe.isByte;
        signQ <= strobe.signExt;
        wbIdx <= dstIdx;
      end
      if (strobe.takeData)
        loadData <= byteQ ? {{(DATA_W-8){signQ & selByte[7]}}, selByte} : memRdata;
    end
  end

  assign memAddr = addrQ;
  assign memBe = beQ;
  assign memWdata = wdataQ;
endmodule

// File: rtl/lsu16.sv
module lsu16
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [4:0]        opCode,
  input  logic [DATA_W-1:0] dstRegVal,
  input  logic [DATA_W-1:0] srcRegVal,
  input  logic [OFF_W-1:0]  offset,
  input  logic [IDX_W-1:0]  dstIdx,
  output logic [DATA_W-1:0] memAddr,
  output logic [LANES-1:0]  memBe,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              memReq,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady,
  output logic              loadValid,
  output logic [DATA_W-1:0] loadData,
  output logic [IDX_W-1:0]  wbIdx,
  output logic              faultMisalign,
  output logic              faultIllegal,
  output logic              busy
);
  lsu_strobe_t strobe;
  logic misaligned;

  lsu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .misaligned(misaligned), .memReady(memReady), .strobe(strobe),
    .memReq(memReq), .memWe(memWe), .loadValid(loadValid),
    .faultMisalign(faultMisalign), .faultIllegal(faultIllegal), .busy(busy)
  );

  lsu_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .dstRegVal(dstRegVal),
    .srcRegVal(srcRegVal), .offset(offset), .dstIdx(dstIdx),
    .memRdata(memRdata), .misaligned(misaligned), .memAddr(memAddr),
    .memBe(memBe), .memWdata(memWdata), .loadData(loadData), .wbIdx(wbIdx)
  );
endmodule

// File: rtl/lsu16_checker.sv
module lsu16_checker
  import lsu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] memAddr,
  input logic [LANES-1:0]  memBe,
  input logic [DATA_W-1:0] memWdata,
  input logic              memWe,
  input logic              memReq,
  input logic              memReady,
  input logic              loadValid,
  input logic              faultMisalign,
  input logic              faultIllegal,
  input logic              busy
);
  // R9: request fields stay put until the memory answers
  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memBe) &&
    $stable(memWdata) && $stable(memWe));

  // R9: busy tracks an outstanding request
  a_r9_busy_req: assert property (@(posedge clk) disable iff (!rst_n)
    busy == memReq);

  // R2: a write strobe only rides on a request
  a_r2_we_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> memReq);

  // R3: load result only after a completed read
  a_r3_load_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    loadValid |-> $past(memReq && memReady && !memWe));

  // R7: an issued full-width access is always even
  a_r7_half_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && (memBe == '1) |-> !memAddr[0]);

  // R7: a misalign fault comes with no traffic
  a_r7_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    faultMisalign |-> !memReq && !loadValid);

  // R8: an illegal opcode comes with no traffic
  a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    faultIllegal |-> !memReq && !faultMisalign && !loadValid);

  // R4: a request always enables at least one lane
  a_r4_lanes_on: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> memBe != '0);
endmodule

bind lsu16 lsu16_checker u_chk (
  .clk(clk), .rst_n(rst_n), .memAddr(memAddr), .memBe(memBe),
  .memWdata(memWdata), .memWe(memWe), .memReq(memReq), .memReady(memReady),
  .loadValid(loadValid), .faultMisalign(faultMisalign),
  .faultIllegal(faultIllegal), .busy(busy)
);

// File: tb/sim_lsu16.sv
module sim_lsu16;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic opValid = 1'b0;
  logic [4:0] opCode = '0, offset = '0;
  logic [15:0] dstRegVal = '0, srcRegVal = '0;
  logic [2:0] dstIdx = '0;
  logic [15:0] memAddr, memWdata, memRdata, loadData;
  logic [1:0] memBe;
  logic memWe, memReq, memReady = 1'b0, loadValid, faultMisalign, faultIllegal, busy;
  logic [2:0] wbIdx;
  logic [7:0] mem [64];

  int testCount = 0, failCount = 0;
  bit done = 0;

  // observed results of the last access
  logic rReq, rWe, rLv, rFm, rFi, rStable;
  logic [15:0] rAddr, rWd, rLd;
  logic [1:0] rBe;
  logic [2:0] rIdx;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign memRdata = {mem[{memAddr[5:1], 1'b1}], mem[{memAddr[5:1], 1'b0}]};

  lsu16 u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [4:0] op, input logic [15:0] dv, input logic [15:0] sv,
                     input logic [4:0] off, input logic [2:0] idx, input int waits);
    @(negedge clk);
    opValid = 1; opCode = op; dstRegVal = dv; srcRegVal = sv; offset = off; dstIdx = idx;
    @(negedge clk);
    opValid = 0;
    rReq = memReq; rAddr = memAddr; rBe = memBe; rWd = memWdata; rWe = memWe;
    rFm = faultMisalign; rFi = faultIllegal; rStable = 1;
    if (rReq) begin
      for (int i = 0; i < waits; i++) begin
        @(negedge clk);
        if (!memReq || !busy || memAddr != rAddr || memBe != rBe || memWdata != rWd ||
            memWe != rWe) rStable = 0;
      end
      memReady = 1;
      if (memWe) for (int b = 0; b < 2; b++)
        if (memBe[b]) mem[{memAddr[5:1], 1'(b)}] = memWdata[8*b +: 8];
      @(negedge clk);
      memReady = 0;
    end else begin
      @(negedge clk);
    end
    rLv = loadValid; rLd = loadData; rIdx = wbIdx;
  endtask

  task automatic t_reset;
    chk(!memReq && !memWe && !loadValid && !faultMisalign && !faultIllegal && !busy,
        "R11", "outputs after reset",
        {memReq, memWe, loadValid, faultMisalign, faultIllegal, busy}, 0);
  endtask

  task automatic t_half_store_load;
    run(5'h08, 16'h0010, 16'hBEEF, 5'b11110, 3'd1, 0);
    chk(rReq && rAddr == 16'h000E, "R1", "store address", rAddr, 16'h000E);
    chk(rBe == 2'b11 && rWe && rWd == 16'hBEEF, "R2", "store be/data",
        {rBe, rWd}, {2'b11, 16'hBEEF});
    chk(mem[14] == 8'hEF && mem[15] == 8'hBE, "R2", "little-endian bytes",
        {mem[15], mem[14]}, 16'hBEEF);
    chk(!rLv, "R2", "no write-back on store", rLv, 0);
    run(5'h09, 16'h0100, 16'h000E, 5'd0, 3'd6, 0);
    chk(rLv && rLd == 16'hBEEF && rIdx == 3'd6, "R3", "halfword load",
        rLd, 16'hBEEF);
    @(negedge clk);
    chk(!loadValid, "R3", "loadValid one cycle", loadValid, 0);
  endtask

  task automatic t_load_wait;
    mem[20] = 8'h34; mem[21] = 8'h12;
    run(5'h09, 16'h0100, 16'h0016, 5'b11110, 3'd5, 3);
    chk(rAddr == 16'h0014, "R3", "load base from source", rAddr, 16'h0014);
    chk(rStable, "R9", "request held over wait states", rStable, 1);
    chk(rLv && rLd == 16'h1234 && rIdx == 3'd5, "R3", "load after waits",
        rLd, 16'h1234);
  endtask

  task automatic t_wrap;
    mem[2] = 8'hCD; mem[3] = 8'hAB;
    run(5'h09, 16'h0000, 16'hFFFE, 5'd4, 3'd2, 0);
    chk(rAddr == 16'h0002, "R1", "address wraps", rAddr, 16'h0002);
    chk(rLd == 16'hABCD, "R1", "wrapped load", rLd, 16'hABCD);
  endtask

  task automatic t_byte_store;
    mem[30] = 8'hAA; mem[31] = 8'hBB;
    run(5'h0A, 16'h001F, 16'h1255, 5'd0, 3'd0, 1);
    chk(rBe == 2'b10 && rWd[15:8] == 8'h55 && rWe, "R4", "odd byte store",
        {rBe, rWd[15:8]}, {2'b10, 8'h55});
    chk(mem[31] == 8'h55 && mem[30] == 8'hAA, "R4", "odd lane only",
        {mem[31], mem[30]}, 16'h55AA);
    run(5'h0A, 16'h001C, 16'h9966, 5'd2, 3'd0, 0);
    chk(rAddr == 16'h001E && rBe == 2'b01 && rWd[7:0] == 8'h66, "R4",
        "even byte store", {rBe, rWd[7:0]}, {2'b01, 8'h66});
    chk(mem[30] == 8'h66 && mem[31] == 8'h55, "R4", "even lane only",
        {mem[31], mem[30]}, 16'h5566);
  endtask

  task automatic t_byte_load;
    mem[40] = 8'h80; mem[41] = 8'h7F;
    run(5'h0B, 16'h0, 16'h0029, 5'd0, 3'd3, 0);
    chk(rLd == 16'h007F, "R5", "signed odd lane positive", rLd, 16'h007F);
    run(5'h0B, 16'h0, 16'h0028, 5'd0, 3'd3, 0);
    chk(rLd == 16'hFF80, "R5", "signed even lane negative", rLd, 16'hFF80);
    run(5'h0C, 16'h0, 16'h0028, 5'd0, 3'd4, 0);
    chk(rLd == 16'h0080 && rIdx == 3'd4, "R6", "unsigned even lane", rLd, 16'h0080);
    mem[41] = 8'hF1;
    run(5'h0C, 16'h0, 16'h002A, 5'b11111, 3'd4, 0);
    chk(rLd == 16'h00F1, "R6", "unsigned odd lane", rLd, 16'h00F1);
  endtask

  task automatic t_misalign;
    mem[2] = 8'h11; mem[3] = 8'h22;
    run(5'h09, 16'h0, 16'h0011, 5'd0, 3'd1, 0);
    chk(rFm && !rReq && !rLv, "R7", "odd halfword load faults",
        {rFm, rReq, rLv}, 3'b100);
    run(5'h08, 16'h0003, 16'hFFFF, 5'd0, 3'd1, 0);
    chk(rFm && !rReq, "R7", "odd halfword store faults", {rFm, rReq}, 2'b10);
    chk(mem[2] == 8'h11 && mem[3] == 8'h22, "R7", "memory untouched",
        {mem[3], mem[2]}, 16'h2211);
    chk(!faultMisalign, "R7", "fault one cycle", faultMisalign, 0);
  endtask

  task automatic t_illegal;
    for (int op = 5'h0D; op <= 5'h0F; op++) begin
      run(5'(op), 16'h0002, 16'h0002, 5'd0, 3'd1, 0);
      chk(rFi && !rReq && !rFm && !rLv, "R8", "reserved opcode", {rFi, rReq}, 2'b10);
    end
    chk(!faultIllegal, "R8", "illegal flag one cycle", faultIllegal, 0);
  endtask

  task automatic t_ignored;
    run(5'h00, 16'h0003, 16'h0003, 5'd0, 3'd1, 0);
    chk(!rReq && !rFm && !rFi && !rLv, "R10", "arith opcode ignored",
        {rReq, rFm, rFi, rLv}, 0);
    run(5'h1C, 16'h0001, 16'h0001, 5'd0, 3'd1, 0);
    chk(!rReq && !rFm && !rFi && !rLv && !busy, "R10", "special opcode ignored",
        {rReq, rFm, rFi, rLv}, 0);
  endtask

  task automatic t_busy_drop;
    mem[50] = 8'h44; mem[51] = 8'h33;
    @(negedge clk);
    opValid = 1; opCode = 5'h09; srcRegVal = 16'h0032; offset = 0; dstIdx = 3'd7;
    @(negedge clk);
    opCode = 5'h08; dstRegVal = 16'h0032; srcRegVal = 16'hDEAD;
    chk(busy && !memWe && memAddr == 16'h0032, "R9", "busy on pending load",
        {busy, memWe}, 2'b10);
    @(negedge clk);
    opValid = 0; memReady = 1;
    @(negedge clk);
    memReady = 0;
    chk(loadValid && loadData == 16'h3344, "R9", "pending load completes",
        loadData, 16'h3344);
    @(negedge clk);
    chk(!memReq && !busy && mem[50] == 8'h44, "R9", "store offered while busy dropped",
        {memReq, busy}, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_half_store_load();
    t_load_wait();
    t_wrap();
    t_byte_store();
    t_byte_load();
    t_misalign();
    t_illegal();
    t_ignored();
    t_busy_drop();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule